// File: doc/BRIEF.md
# Packed SIMD Add-Subtract Unit

This unit performs lane-parallel addition and subtraction on two 32-bit operands. There are four operation groups. The first is unsigned halfword arithmetic, which can saturate and which reports overflow. The second is unsigned byte averaging. The third is signed halfword averaging. The fourth is signed full-word averaging. Each averaging group can round half up. A 4-bit operation code selects the group, the direction and the modifier. A datapath stage issues one operation per cycle and collects the result one cycle later.

The result and an overflow strobe are registered on the clock edge that follows a valid request, and a valid pulse marks them. The strobe is meant to be OR-ed into a sticky flag that is stored elsewhere. Cycles without a request leave the result unchanged.

Top module: `simd_addsub`

## Requirements
- R1: While reset is active and after it is released, `out_valid`, `result` and `ovf_set` are all zero until the first request has been registered.
- R2: `out_valid` is high in exactly the cycle after `in_valid` was high. In a cycle after `in_valid` was low, `result` keeps its previous value and `ovf_set` is 0.
- R3: Unsigned halfword add (op 0000 wraps, op 0001 saturates) adds each 16-bit lane. When a lane's sum exceeds 0xFFFF, overflow is reported. That lane then becomes 0xFFFF with saturation, or keeps the low 16 bits without it.
- R4: Unsigned halfword subtract (op 0010 wraps, op 0011 saturates) reports overflow for each lane where opa < opb. Such a lane is forced to 0x0000 with saturation, or wraps modulo 2^16 without it.
- R5: `ovf_set` is raised for any overflowing lane, whether or not saturation is selected. It is only ever high together with `out_valid`.
- R6: Unsigned byte averaging (op 0100 add, 0110 subtract) forms a 9-bit sum or two's-complement difference for each byte lane. It then shifts right by one and keeps 8 bits.
- R7: The rounding variants (op bit 0 set in any averaging group) add 1 to the full-width intermediate before the shift.
- R8: Signed halfword averaging (op 1000 add, 1010 subtract) uses a 17-bit signed intermediate and an arithmetic right shift by one.
- R9: Signed word averaging (op 1100 add, 1110 subtract) uses a 33-bit signed intermediate and an arithmetic right shift by one.
- R10: Averaging operations (op bits [3:2] not 00) never raise `ovf_set`.
- R11: Lane 0 occupies the least significant bits, and no carry passes between lanes.
- R12: The op code is encoded as follows. Bits [3:2] pick the group: 00 unsigned halfword, 01 unsigned byte averaging, 10 signed halfword averaging, 11 signed word averaging. Bit 1 selects subtract. Bit 0 selects saturation in group 00 and rounding in the other groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request qualifier |
| op_sel | input | 4 | Operation code (see R12) |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Registered lane results |
| ovf_set | output | 1 | Overflow strobe for a sticky flag |

## Verification
A wrong carry or sign extension inside one lane shows up as a wrong `result` in the very next cycle. It can also corrupt the neighbouring lane, which the bench catches by comparing all 32 bits against its model on every clock. A faulty overflow decision shows as a missing or spurious `ovf_set` pulse in the same cycle as `out_valid`. A broken hold path shows as `result` changing one cycle after an idle cycle. The directed corners cover lane-boundary carries, 0x8000 operands, the rounding wrap of a byte difference of -1, and word extremes.

// File: rtl/simd_addsub_pkg.sv
package simd_addsub_pkg;
    localparam int OP_W = 4;

    typedef enum logic [1:0] {
        GRP_UHALF  = 2'b00,
        GRP_UBYTEH = 2'b01,
        GRP_SHALFH = 2'b10,
        GRP_SWORDH = 2'b11
    } grp_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] result;
        logic        ovf;
    } stage_t;
endpackage

// File: rtl/simd_usat_lane.sv
module simd_usat_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);
    logic [W:0]   sum_w;
    logic [W-1:0] diff_w;
    logic         borrow;

    always_comb begin
        sum_w  = {1'b0, a} + {1'b0, b};
        diff_w = a - b;
        borrow = (a < b);
        ovf    = sub ? borrow : sum_w[W];
        if (sat && ovf) begin
            res = sub ? '0 : '1;
        end else begin
            res = sub ? diff_w : sum_w[W-1:0];
        end
    end
endmodule

// File: rtl/simd_halve_lane.sv
module simd_halve_lane #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         rnd,
    output logic [W-1:0] res
);
    logic [W:0] ext_a;
    logic [W:0] ext_b;
    logic [W:0] mid;

    always_comb begin
        ext_a = SIGNED ? {a[W-1], a} : {1'b0, a};
        ext_b = SIGNED ? {b[W-1], b} : {1'b0, b};
        mid   = (sub ? (ext_a - ext_b) : (ext_a + ext_b)) + {{W{1'b0}}, rnd};
        res   = mid[W:1];
    end
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op_sel,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf_set
);
    localparam int HW     = DATA_W / 2;
    localparam int BW     = DATA_W / 4;
    localparam int N_HALF = DATA_W / HW;
    localparam int N_BYTE = DATA_W / BW;

    grp_e grp;
    logic is_sub;
    logic modifier;

    logic [DATA_W-1:0] uh_res;
    logic [N_HALF-1:0] uh_ovf;
    logic [DATA_W-1:0] ub_res;
    logic [DATA_W-1:0] sh_res;
    logic [DATA_W-1:0] sw_res;

    stage_t st_d, st_q;

    assign grp      = grp_e'(op_sel[3:2]);
    assign is_sub   = op_sel[1];
    assign modifier = op_sel[0];

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        simd_usat_lane #(.W(HW)) u_usat (
            .a   (opa[h*HW +: HW]),
            .b   (opb[h*HW +: HW]),
            .sub (is_sub),
            .sat (modifier),
            .res (uh_res[h*HW +: HW]),
            .ovf (uh_ovf[h])
        );
        simd_halve_lane #(.W(HW), .SIGNED(1'b1)) u_shalf (
            .a   (opa[h*HW +: HW]),
            .b   (opb[h*HW +: HW]),
            .sub (is_sub),
            .rnd (modifier),
            .res (sh_res[h*HW +: HW])
        );
    end

    for (genvar q = 0; q < N_BYTE; q++) begin : g_byte
        simd_halve_lane #(.W(BW), .SIGNED(1'b0)) u_ubyte (
            .a   (opa[q*BW +: BW]),
            .b   (opb[q*BW +: BW]),
            .sub (is_sub),
            .rnd (modifier),
            .res (ub_res[q*BW +: BW])
        );
    end

    simd_halve_lane #(.W(DATA_W), .SIGNED(1'b1)) u_sword (
        .a   (opa),
        .b   (opb),
        .sub (is_sub),
        .rnd (modifier),
        .res (sw_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        st_d.ovf   = 1'b0;
        if (in_valid) begin
            case (grp)
                GRP_UHALF: begin
                    st_d.result = uh_res;
                    st_d.ovf    = |uh_ovf;
                end
                GRP_UBYTEH: st_d.result = ub_res;
                GRP_SHALFH: st_d.result = sh_res;
                default:    st_d.result = sw_res;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.result;
    assign ovf_set   = st_q.ovf;
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op_sel,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        ovf_set
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !ovf_set && $stable(result))); // R2
    AST_OVF_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |-> out_valid); // R5
    AST_HALVE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[3:2] != 2'b00) |=> !ovf_set); // R10
    AST_ADD_SAT_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'b0001 && (17'(opa[15:0]) + 17'(opb[15:0])) > 17'h0FFFF)
        |=> (result[15:0] == 16'hFFFF && ovf_set)); // R3
    AST_SUB_SAT_LANE1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'b0011 && opa[31:16] < opb[31:16])
        |=> (result[31:16] == 16'h0000 && ovf_set)); // R4
endmodule

bind simd_addsub simd_addsub_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result),
    .ovf_set   (ovf_set)
);

// File: tb/simd_addsub_tb.sv
module simd_addsub_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_set;

    int n_checks = 0;
    int n_fails  = 0;

    logic        exp_valid = 1'b0;
    logic [31:0] exp_res   = '0;
    logic        exp_ovf   = 1'b0;
    logic [3:0]  exp_op    = '0;

    always #4 clk = ~clk;

    simd_addsub u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result),
        .ovf_set(ovf_set)
    );

    function automatic longint sx(longint v, int w);
        return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
    endfunction

    // behavioural reference: returns {ovf, result}
    function automatic logic [32:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b);
        longint x, y, s, r;
        logic ov;
        int grp;
        bit sb, md;
        grp = int'(op[3:2]); sb = op[1]; md = op[0];
        r = 0; ov = 1'b0;
        if (grp == 0) begin
            for (int i = 0; i < 2; i++) begin
                x = (longint'(a) >> (16*i)) & 64'hFFFF;
                y = (longint'(b) >> (16*i)) & 64'hFFFF;
                if (!sb) begin
                    s = x + y;
                    if (s > 65535) begin ov = 1'b1; s = md ? 65535 : s - 65536; end
                end else begin
                    if (x < y) begin ov = 1'b1; s = md ? 0 : x - y + 65536; end
                    else s = x - y;
                end
                r = r | (s << (16*i));
            end
        end else if (grp == 1) begin
            for (int i = 0; i < 4; i++) begin
                x = (longint'(a) >> (8*i)) & 64'hFF;
                y = (longint'(b) >> (8*i)) & 64'hFF;
                s = (sb ? x - y : x + y) + (md ? 1 : 0);
                s = s >>> 1;
                r = r | ((s & 64'hFF) << (8*i));
            end
        end else if (grp == 2) begin
            for (int i = 0; i < 2; i++) begin
                x = sx((longint'(a) >> (16*i)) & 64'hFFFF, 16);
                y = sx((longint'(b) >> (16*i)) & 64'hFFFF, 16);
                s = (sb ? x - y : x + y) + (md ? 1 : 0);
                s = s >>> 1;
                r = r | ((s & 64'hFFFF) << (16*i));
            end
        end else begin
            x = sx(longint'(a), 32);
            y = sx(longint'(b), 32);
            s = (sb ? x - y : x + y) + (md ? 1 : 0);
            r = (s >>> 1) & 64'hFFFF_FFFF;
        end
        return {ov, r[31:0]};
    endfunction

    function automatic string res_tag(logic [3:0] op);
        case (op[3:2])
            2'b00:   return op[1] ? "R4/R11/R12" : "R3/R11/R12";
            2'b01:   return op[0] ? "R6/R7/R11"  : "R6/R11/R12";
            2'b10:   return op[0] ? "R8/R7/R11"  : "R8/R11/R12";
            default: return op[0] ? "R9/R7"      : "R9/R12";
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // compare outputs at negedge, then drive the next request
    task automatic step(bit v, logic [3:0] op, logic [31:0] a, logic [31:0] b);
        logic [32:0] m;
        @(negedge clk);
        check(out_valid == exp_valid, "R2", "out_valid", longint'(out_valid), longint'(exp_valid));
        check(result == exp_res, exp_valid ? res_tag(exp_op) : "R2 hold", "result",
              longint'(result), longint'(exp_res));
        check(ovf_set == exp_ovf, (exp_valid && exp_op[3:2] == 2'b00) ? "R5" : "R10/R5",
              "ovf_set", longint'(ovf_set), longint'(exp_ovf));
        in_valid = v; op_sel = op; opa = a; opb = b;
        exp_valid = v;
        exp_ovf   = 1'b0;
        if (v) begin
            m = model(op, a, b);
            exp_res = m[31:0];
            exp_ovf = m[32];
            exp_op  = op;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0 && result == '0 && ovf_set == 1'b0, "R1", "reset outputs",
              longint'({out_valid, ovf_set, result}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 4'h0, '0, '0);
        // R3 carry out of lane 0 only; lane 1 must not see it (R11)
        step(1'b1, 4'b0000, 32'h0001_FFFF, 32'h0002_0001);
        step(1'b1, 4'b0001, 32'h0001_FFFF, 32'h0002_0001);
        step(1'b1, 4'b0001, 32'hFFFF_0010, 32'h0001_0020);
        step(1'b1, 4'b0000, 32'h1234_5678, 32'h1111_1111);
        // R4 borrow in lane 1, wrap and saturate
        step(1'b1, 4'b0010, 32'h0001_0005, 32'h0002_0003);
        step(1'b1, 4'b0011, 32'h0001_0005, 32'h0002_0003);
        step(1'b1, 4'b0011, 32'h8000_8000, 32'h8000_7FFF);
        // idle: result holds (R2)
        step(1'b0, 4'b0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        step(1'b0, 4'b0000, '0, '0);
        // R6 / R7 byte averaging including difference of -1 with rounding
        step(1'b1, 4'b0100, 32'hFF01_FF80, 32'hFF02_0180);
        step(1'b1, 4'b0101, 32'hFF01_FF80, 32'hFF02_0180);
        step(1'b1, 4'b0110, 32'h0010_0100, 32'h0111_0001);
        step(1'b1, 4'b0111, 32'h0010_0100, 32'h0111_0001);
        // R8 signed halfword averaging at the extremes
        step(1'b1, 4'b1000, 32'h8000_7FFF, 32'h8000_7FFF);
        step(1'b1, 4'b1001, 32'h8000_FFFF, 32'hFFFF_0000);
        step(1'b1, 4'b1010, 32'h8000_7FFF, 32'h7FFF_8000);
        step(1'b1, 4'b1011, 32'h0000_FFFF, 32'h0001_0000);
        // R9 word averaging
        step(1'b1, 4'b1100, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        step(1'b1, 4'b1101, 32'h8000_0000, 32'hFFFF_FFFF);
        step(1'b1, 4'b1110, 32'h8000_0000, 32'h7FFF_FFFF);
        step(1'b1, 4'b1111, 32'h0000_0000, 32'h0000_0001);
        // random mix with idle gaps
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 5) != 0, 4'($urandom), $urandom, $urandom);
        end
        step(1'b0, 4'h0, '0, '0);
        step(1'b0, 4'h0, '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule